// File: doc/BRIEF.md
# Stream Descriptor Address Generator

This block turns a loaded stream descriptor into a sequence of element addresses. Software, or a neighbouring controller, fills a small set of descriptor fields through a write port and then pulses `start`. The engine then offers one address at a time on a valid/ready output. Each address carries the descriptor's cache-level hint and a flag on the final element. Four access patterns share one descriptor format. They are a strided line, a strided two-dimensional grid walked column first, an indirect gather that fetches each element address from an index vector, and a pointer chase along a linked list.

For the two indirect patterns the engine issues one word read at a time on a request port and waits for the response before it offers anything at the output. The walk position (column, row, and list node pointer) is always visible on output ports. A saved column/row pair can be written back before `start` so that an interrupted stream resumes where it left off. Address arithmetic uses only adders. A resumed walk first steps its accumulators up to the saved position, one step per cycle.

Descriptor field selects (`cfg_sel`): 0 control (`cfg_wdata[1:0]` pattern, `cfg_wdata[2+:HW]` hint), 1 base or list head, 2 column stride or list payload offset, 3 column count, 4 row stride or list next-pointer offset, 5 row count, 6 column position, 7 row position. Pattern codes are 0 line, 1 grid, 2 gather and 3 list.

Top module: `strm_addr_gen`

## Requirements
- R1: Line pattern (code 0): the engine emits base + k*col_stride for k from the column position up to column count - 1, in order, with `out_last` set only on the final one. Row count is not used and the row position must be 0.
- R2: Grid pattern (code 1): addresses are base + r*row_stride + c*col_stride. The column runs fastest; when it wraps to 0 the row advances by one. `out_last` marks the element in the last row and the last column. This includes the single-row and single-column cases.
- R3: Gather pattern (code 2): for each k, the engine reads the word at base + k*col_stride and emits the returned word as the element address, in index order.
- R4: List pattern (code 3): for the node pointer p, the engine reads the next pointer at p + next_offset and, once the response arrives, emits p + payload_offset. `out_last` is set when the returned next pointer is zero; otherwise p becomes that pointer. A zero head emits nothing.
- R5: Every emitted address carries the hint written to control bits [2+HW-1:2].
- R6: A zero column count or zero row count (grid), or a saved position outside the ranges, completes the stream with no address emitted, and `busy` falls.
- R7: While idle, written positions read back on `pos_col`/`pos_row`, and `start` resumes the walk from them. After the final element the position reads row = row count (1 for line and gather) and column 0. After a list completes, `pos_ptr` reads 0.
- R8: While `out_valid` is high and `out_ready` low, `out_valid` stays high and address, hint and last flag do not change.
- R9: Descriptor writes and `start` pulses are ignored while `busy` is high.
- R10: At most one memory read is outstanding. A request is held until `mem_req_ready` is seen, and no output is offered while a request or its response is pending.
- R11: After reset, `busy`, `out_valid` and `mem_req_valid` are low and both positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_sel | input | 3 | Descriptor field select |
| cfg_wdata | input | AW | Descriptor field write data |
| start | input | 1 | Begin walking from the current position |
| busy | output | 1 | Stream in progress |
| pos_col | output | CW | Current column (element index) position |
| pos_row | output | CW | Current row position |
| pos_ptr | output | AW | Current list node pointer |
| out_valid | output | 1 | Element address offered |
| out_ready | input | 1 | Element address accepted |
| out_addr | output | AW | Element address |
| out_hint | output | HW | Cache-level hint |
| out_last | output | 1 | Final element of the stream |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read address (index entry or next-pointer slot) |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | AW | Read response word |

## Verification
The assertions watch the handshake rules on every cycle. Offered addresses and pending requests must hold steady until taken. Output and memory request must never be raised together. Nothing may be raised while idle. The engine must go idle after an accepted last element, and the positions must stay untouched while idle without a write or start. Only the bench scenarios can show that the address sequences are right. They compare each pattern, the single-row and single-column grids, resumed walks, empty streams, list termination and writes made while busy against sequences computed from the descriptor under random backpressure and random response latency.

// File: rtl/strm_pkg.sv
package strm_pkg;

  typedef enum logic [1:0] {
    MD_LINE   = 2'd0,
    MD_GRID   = 2'd1,
    MD_GATHER = 2'd2,
    MD_CHAIN  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEEK  = 3'd1,
    ST_FREQ  = 3'd2,
    ST_FWAIT = 3'd3,
    ST_EMIT  = 3'd4
  } state_e;

  localparam logic [2:0] FLD_CTRL = 3'd0;
  localparam logic [2:0] FLD_BASE = 3'd1;
  localparam logic [2:0] FLD_CSTR = 3'd2;
  localparam logic [2:0] FLD_CLEN = 3'd3;
  localparam logic [2:0] FLD_RSTR = 3'd4;
  localparam logic [2:0] FLD_RLEN = 3'd5;
  localparam logic [2:0] FLD_CPOS = 3'd6;
  localparam logic [2:0] FLD_RPOS = 3'd7;

endpackage

// File: rtl/strm_walk.sv
// Column/row position walker with incremental address accumulators.
module strm_walk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] col_stride,
  input  logic [AW-1:0] row_stride,
  input  logic [CW-1:0] col_len,
  input  logic [CW-1:0] row_len,
  input  logic          we_col,
  input  logic          we_row,
  input  logic [CW-1:0] wdata,
  input  logic          start,
  input  logic          step,
  input  logic          adv,
  output logic [CW-1:0] pos_col,
  output logic [CW-1:0] pos_row,
  output logic [AW-1:0] cur_addr,
  output logic          seek_done,
  output logic          empty,
  output logic          last_elem
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] col_q, col_d, row_q, row_d, tcol_q, tcol_d, trow_q, trow_d;
  logic [AW-1:0] raddr_q, raddr_d, caddr_q, caddr_d;
  logic          upd;
  logic          do_row, do_col;

  always_comb begin
    do_row = 1'b0;
    do_col = 1'b0;
    if (!start && step) begin
      if (row_q != trow_q)      do_row = 1'b1;
      else if (col_q != tcol_q) do_col = 1'b1;
    end else if (!start && adv) begin
      if ((col_q + ONE) == col_len) do_row = 1'b1;
      else                          do_col = 1'b1;
    end
  end

  always_comb begin
    col_d   = col_q;
    row_d   = row_q;
    tcol_d  = tcol_q;
    trow_d  = trow_q;
    raddr_d = raddr_q;
    caddr_d = caddr_q;
    if (start) begin
      tcol_d  = col_q;
      trow_d  = row_q;
      col_d   = '0;
      row_d   = '0;
      raddr_d = base;
      caddr_d = base;
    end else if (do_row) begin
      row_d   = row_q + ONE;
      col_d   = '0;
      raddr_d = raddr_q + row_stride;
      caddr_d = raddr_q + row_stride;
    end else if (do_col) begin
      col_d   = col_q + ONE;
      caddr_d = caddr_q + col_stride;
    end
    if (we_col) col_d = wdata;
    if (we_row) row_d = wdata;
  end

  assign upd = start | do_row | do_col | we_col | we_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      tcol_q  <= '0;
      trow_q  <= '0;
      raddr_q <= '0;
      caddr_q <= '0;
    end else if (upd) begin
      col_q   <= col_d;
      row_q   <= row_d;
      tcol_q  <= tcol_d;
      trow_q  <= trow_d;
      raddr_q <= raddr_d;
      caddr_q <= caddr_d;
    end
  end

  assign pos_col   = col_q;
  assign pos_row   = row_q;
  assign cur_addr  = caddr_q;
  assign seek_done = (col_q == tcol_q) && (row_q == trow_q);
  assign empty     = (col_len == '0) || (row_len == '0) ||
                     (trow_q >= row_len) || (tcol_q >= col_len);
  assign last_elem = ((col_q + ONE) == col_len) && ((row_q + ONE) == row_len);

endmodule

// File: rtl/strm_ctrl.sv
// Sequencing state machine shared by all access patterns.
module strm_ctrl
  import strm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  mode_e mode,
  input  logic  empty,
  input  logic  seek_done,
  input  logic  last_elem,
  input  logic  head_zero,
  input  logic  next_zero,
  input  logic  req_ready,
  input  logic  rsp_valid,
  input  logic  out_ready,
  output logic  walk_start,
  output logic  walk_step,
  output logic  walk_adv,
  output logic  chain_load,
  output logic  chain_next,
  output logic  rsp_capture,
  output logic  req_valid,
  output logic  out_valid,
  output logic  busy
);

  state_e state_q, state_d;
  logic   indirect;

  assign indirect = (mode == MD_GATHER) || (mode == MD_CHAIN);

  always_comb begin
    state_d     = state_q;
    walk_start  = 1'b0;
    walk_step   = 1'b0;
    walk_adv    = 1'b0;
    chain_load  = 1'b0;
    chain_next  = 1'b0;
    rsp_capture = 1'b0;
    req_valid   = 1'b0;
    out_valid   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          walk_start = (mode != MD_CHAIN);
          chain_load = (mode == MD_CHAIN);
          state_d    = ST_SEEK;
        end
      end
      ST_SEEK: begin
        if (mode == MD_CHAIN) begin
          state_d = head_zero ? ST_IDLE : ST_FREQ;
        end else if (empty) begin
          state_d = ST_IDLE;
        end else if (seek_done) begin
          state_d = indirect ? ST_FREQ : ST_EMIT;
        end else begin
          walk_step = 1'b1;
        end
      end
      ST_FREQ: begin
        req_valid = 1'b1;
        if (req_ready) state_d = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (rsp_valid) begin
          rsp_capture = 1'b1;
          state_d     = ST_EMIT;
        end
      end
      ST_EMIT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          if (mode == MD_CHAIN) begin
            chain_next = 1'b1;
            state_d    = next_zero ? ST_IDLE : ST_FREQ;
          end else begin
            walk_adv = 1'b1;
            if (last_elem)     state_d = ST_IDLE;
            else if (indirect) state_d = ST_FREQ;
            else               state_d = ST_EMIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/strm_addr_gen.sv
module strm_addr_gen
  import strm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int HW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] pos_col,
  output logic [CW-1:0] pos_row,
  output logic [AW-1:0] pos_ptr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [HW-1:0] out_hint,
  output logic          out_last,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  // Descriptor fields
  mode_e         mode_q;
  logic [HW-1:0] hint_q;
  logic [AW-1:0] base_q, cstr_q, rstr_q;
  logic [CW-1:0] clen_q, rlen_q;
  logic          wr_ok;

  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q <= MD_LINE;
      hint_q <= '0;
      base_q <= '0;
      cstr_q <= '0;
      rstr_q <= '0;
      clen_q <= '0;
      rlen_q <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        FLD_CTRL: begin
          mode_q <= mode_e'(cfg_wdata[1:0]);
          hint_q <= cfg_wdata[2 +: HW];
        end
        FLD_BASE: base_q <= cfg_wdata;
        FLD_CSTR: cstr_q <= cfg_wdata;
        FLD_CLEN: clen_q <= cfg_wdata[CW-1:0];
        FLD_RSTR: rstr_q <= cfg_wdata;
        FLD_RLEN: rlen_q <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // Control and walker interconnect
  logic          walk_start, walk_step, walk_adv;
  logic          chain_load, chain_next, rsp_capture;
  logic          seek_done, empty, last_elem;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] row_eff;
  logic          start_ok;

  assign row_eff  = (mode_q == MD_GRID) ? rlen_q : CW'(1);
  assign start_ok = start && !busy;

  strm_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_ns),
    .base       (base_q),
    .col_stride (cstr_q),
    .row_stride (rstr_q),
    .col_len    (clen_q),
    .row_len    (row_eff),
    .we_col     (wr_ok && (cfg_sel == FLD_CPOS)),
    .we_row     (wr_ok && (cfg_sel == FLD_RPOS)),
    .wdata      (cfg_wdata[CW-1:0]),
    .start      (walk_start),
    .step       (walk_step),
    .adv        (walk_adv),
    .pos_col    (pos_col),
    .pos_row    (pos_row),
    .cur_addr   (cur_addr),
    .seek_done  (seek_done),
    .empty      (empty),
    .last_elem  (last_elem)
  );

  // List pointer and captured response word
  logic [AW-1:0] ptr_q, ptr_d, rsp_q, rsp_d;
  logic          ptr_en;

  always_comb begin
    ptr_d = ptr_q;
    if (chain_load)      ptr_d = base_q;
    else if (chain_next) ptr_d = rsp_q;
    rsp_d = rsp_capture ? mem_rsp_data : rsp_q;
  end

  assign ptr_en = chain_load | chain_next;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ptr_q <= '0;
      rsp_q <= '0;
    end else begin
      if (ptr_en)      ptr_q <= ptr_d;
      if (rsp_capture) rsp_q <= rsp_d;
    end
  end

  strm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start       (start_ok),
    .mode        (mode_q),
    .empty       (empty),
    .seek_done   (seek_done),
    .last_elem   (last_elem),
    .head_zero   (ptr_q == '0),
    .next_zero   (rsp_q == '0),
    .req_ready   (mem_req_ready),
    .rsp_valid   (mem_rsp_valid),
    .out_ready   (out_ready),
    .walk_start  (walk_start),
    .walk_step   (walk_step),
    .walk_adv    (walk_adv),
    .chain_load  (chain_load),
    .chain_next  (chain_next),
    .rsp_capture (rsp_capture),
    .req_valid   (mem_req_valid),
    .out_valid   (out_valid),
    .busy        (busy)
  );

  // Output and request muxes
  always_comb begin
    case (mode_q)
      MD_CHAIN: begin
        out_addr     = ptr_q + cstr_q;
        out_last     = (rsp_q == '0);
        mem_req_addr = ptr_q + rstr_q;
      end
      MD_GATHER: begin
        out_addr     = rsp_q;
        out_last     = last_elem;
        mem_req_addr = cur_addr;
      end
      default: begin
        out_addr     = cur_addr;
        out_last     = last_elem;
        mem_req_addr = cur_addr;
      end
    endcase
  end

  assign out_hint = hint_q;
  assign pos_ptr  = ptr_q;

endmodule

// File: rtl/strm_addr_gen_chk.sv
module strm_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int HW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          start,
  input logic          busy,
  input logic [CW-1:0] pos_col,
  input logic [CW-1:0] pos_row,
  input logic [AW-1:0] pos_ptr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [HW-1:0] out_hint,
  input logic          out_last,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr
);

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
                                $stable(out_hint) && $stable(out_last));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && mem_req_valid));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !mem_req_valid);

  a_r1_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !busy);

  a_r7_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cfg_we && !start |=> $stable(pos_col) && $stable(pos_row) &&
                                   $stable(pos_ptr));

endmodule

bind strm_addr_gen strm_addr_gen_chk #(.AW(AW), .CW(CW), .HW(HW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .start         (start),
  .busy          (busy),
  .pos_col       (pos_col),
  .pos_row       (pos_row),
  .pos_ptr       (pos_ptr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_hint      (out_hint),
  .out_last      (out_last),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_strm_addr_gen.sv
module tb_strm_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        start = 1'b0;
  logic        busy;
  logic [15:0] pos_col, pos_row;
  logic [31:0] pos_ptr;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [1:0]  out_hint;
  logic        out_last;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;

  always #4 clk = ~clk;

  strm_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .pos_col(pos_col),
    .pos_row(pos_row), .pos_ptr(pos_ptr), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_hint(out_hint),
    .out_last(out_last), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  logic [31:0] got_addr [0:63];
  logic [1:0]  got_hint [0:63];
  logic        got_last [0:63];
  int          got_n = 0;
  logic [31:0] exp_addr [0:63];
  logic [1:0]  exp_hint [0:63];
  logic        exp_last [0:63];
  int          exp_n = 0;

  logic [31:0] node [0:7];
  int          node_n = 0;
  logic [31:0] nxt_off = 32'd0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    for (int i = 0; i < node_n; i++)
      if (a == node[i] + nxt_off) return (i + 1 < node_n) ? node[i+1] : 32'd0;
    return (a ^ 32'hA5A5_0F0F) + 32'd3;
  endfunction

  // Output collector with random backpressure; also checks hold (R8).
  initial begin
    logic        r;
    logic        hold;
    logic [31:0] h_addr;
    hold = 1'b0;
    h_addr = 32'd0;
    forever begin
      @(negedge clk);
      if (hold) begin
        check("R8", "held valid", {31'd0, out_valid}, 32'd1);
        check("R8", "held addr", out_addr, h_addr);
      end
      r = ($urandom_range(0, 3) != 0);
      out_ready = r;
      hold = out_valid && !r;
      h_addr = out_addr;
      if (out_valid && r && got_n < 64) begin
        got_addr[got_n] = out_addr;
        got_hint[got_n] = out_hint;
        got_last[got_n] = out_last;
        got_n++;
      end
    end
  end

  // Memory responder: random accept, 1..3 cycle latency (R10 checks).
  initial begin
    int          cd;
    logic [31:0] pa;
    cd = 0;
    pa = 32'd0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cd > 0) begin
        check("R10", "quiet while pending", {30'd0, out_valid, mem_req_valid}, 32'd0);
        mem_req_ready = 1'b0;
        cd--;
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_fn(pa);
        end
      end else begin
        mem_req_ready = $urandom_range(0, 1) != 0;
        if (mem_req_valid && mem_req_ready) begin
          pa = mem_req_addr;
          cd = $urandom_range(1, 3);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int mode, input int hint, input logic [31:0] base,
                       input logic [31:0] cs, input int cl, input logic [31:0] rs,
                       input int rl, input int pc, input int pr);
    wr(3'd0, 32'(mode) | (32'(hint) << 2));
    wr(3'd1, base);
    wr(3'd2, cs);
    wr(3'd3, 32'(cl));
    wr(3'd4, rs);
    wr(3'd5, 32'(rl));
    wr(3'd6, 32'(pc));
    wr(3'd7, 32'(pr));
  endtask

  task automatic run(input bit poke);
    int t;
    got_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      cfg_we = 1'b1;
      cfg_sel = 3'd3;
      cfg_wdata = 32'd1;
      start = 1'b1;
      @(negedge clk);
      cfg_sel = 3'd2;
      cfg_wdata = 32'h777;
      start = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    t = 0;
    while (busy && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 4000) begin
      n_chk++;
      n_err++;
      $display("FAIL timeout: actual busy expected idle");
    end
  endtask

  task automatic exp_grid(input int mode, input int hint, input logic [31:0] base,
                          input logic [31:0] cs, input int cl, input logic [31:0] rs,
                          input int rl, input int pc, input int pr);
    int rows;
    logic [31:0] a;
    rows = (mode == 1) ? rl : 1;
    exp_n = 0;
    for (int r = pr; r < rows; r++)
      for (int c = ((r == pr) ? pc : 0); c < cl; c++) begin
        a = base + 32'(r) * rs + 32'(c) * cs;
        if (mode == 2) a = mem_fn(a);
        exp_addr[exp_n] = a;
        exp_hint[exp_n] = 2'(hint);
        exp_last[exp_n] = 1'b0;
        exp_n++;
      end
    if (exp_n > 0) exp_last[exp_n-1] = 1'b1;
  endtask

  task automatic exp_chain(input int hint, input logic [31:0] pay);
    exp_n = 0;
    for (int i = 0; i < node_n; i++) begin
      exp_addr[i] = node[i] + pay;
      exp_hint[i] = 2'(hint);
      exp_last[i] = (i == node_n - 1);
      exp_n++;
    end
  endtask

  task automatic cmp(input string tag);
    check(tag, "count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(tag, "addr", got_addr[i], exp_addr[i]);
      check("R5", "hint", {30'd0, got_hint[i]}, {30'd0, exp_hint[i]});
      check(tag, "last", {31'd0, got_last[i]}, {31'd0, exp_last[i]});
    end
  endtask

  task automatic grid_case(input string tag, input int mode, input int hint,
                           input logic [31:0] base, input logic [31:0] cs, input int cl,
                           input logic [31:0] rs, input int rl, input int pc,
                           input int pr, input bit poke);
    setup(mode, hint, base, cs, cl, rs, rl, pc, pr);
    exp_grid(mode, hint, base, cs, cl, rs, rl, pc, pr);
    run(poke);
    cmp(tag);
    if (exp_n > 0) begin
      check("R7", "end row", 32'(pos_row), (mode == 1) ? 32'(rl) : 32'd1);
      check("R7", "end col", 32'(pos_col), 32'd0);
    end
  endtask

  task automatic chain_case(input int n, input int hint, input logic [31:0] pay,
                            input logic [31:0] noff);
    node_n = n;
    nxt_off = noff;
    for (int i = 0; i < n; i++)
      node[i] = 32'h0001_0000 + 32'($urandom_range(1, 255)) * 32'h100 + 32'(i) * 32'h10_0000;
    setup(3, hint, (n > 0) ? node[0] : 32'd0, pay, 0, noff, 0, 0, 0);
    exp_chain(hint, pay);
    run(1'b0);
    cmp("R4");
    check("R7", "end ptr", pos_ptr, 32'd0);
    node_n = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11", "busy", {31'd0, busy}, 32'd0);
    check("R11", "valid", {30'd0, out_valid, mem_req_valid}, 32'd0);
    check("R11", "pos", {pos_row, pos_col}, 32'd0);

    // R1 line, R5 hint
    grid_case("R1", 0, 1, 32'h1000, 32'd4, 5, 32'd0, 0, 0, 0, 1'b0);
    // R2 grid 3 rows x 4 cols, single row, single column
    grid_case("R2", 1, 2, 32'h8000, 32'd8, 4, 32'h100, 3, 0, 0, 1'b0);
    grid_case("R2", 1, 3, 32'h9000, 32'd4, 4, 32'h40, 1, 0, 0, 1'b0);
    grid_case("R2", 1, 0, 32'hA000, 32'd4, 1, 32'h80, 3, 0, 0, 1'b0);

    // R7: position readback and resume
    setup(1, 1, 32'h4000, 32'd2, 4, 32'h20, 3, 2, 1);
    check("R7", "readback col", 32'(pos_col), 32'd2);
    check("R7", "readback row", 32'(pos_row), 32'd1);
    exp_grid(1, 1, 32'h4000, 32'd2, 4, 32'h20, 3, 2, 1);
    run(1'b0);
    cmp("R7");
    grid_case("R7", 0, 2, 32'h500, 32'd16, 6, 32'd0, 0, 4, 0, 1'b0);

    // R3 gather
    grid_case("R3", 2, 3, 32'h2000, 32'd4, 4, 32'd0, 0, 0, 0, 1'b0);
    // R4 chain, including a zero head
    chain_case(4, 2, 32'h8, 32'h4);
    chain_case(0, 1, 32'h8, 32'h4);
    chain_case(1, 3, 32'hC, 32'h0);

    // R6 empty streams
    grid_case("R6", 0, 0, 32'h100, 32'd4, 0, 32'd0, 0, 0, 0, 1'b0);
    grid_case("R6", 1, 0, 32'h100, 32'd4, 3, 32'd8, 0, 0, 0, 1'b0);
    grid_case("R6", 2, 0, 32'h100, 32'd4, 0, 32'd0, 0, 0, 0, 1'b0);
    grid_case("R6", 0, 0, 32'h100, 32'd4, 3, 32'd0, 0, 5, 0, 1'b0);

    // R9 writes and start while busy
    grid_case("R9", 0, 1, 32'h3000, 32'd4, 6, 32'd0, 0, 0, 0, 1'b1);
    grid_case("R9", 1, 2, 32'h3000, 32'd4, 3, 32'h40, 2, 0, 0, 1'b1);

    // Random streams
    for (int k = 0; k < 24; k++) begin
      int m;
      m = $urandom_range(0, 2);
      grid_case((m == 0) ? "R1" : (m == 1) ? "R2" : "R3", m, $urandom_range(0, 3),
                32'($urandom_range(0, 65535)) << 4, 32'($urandom_range(0, 64)) << 2,
                $urandom_range(1, 5), 32'($urandom_range(0, 255)) << 4,
                $urandom_range(1, 4), 0, 0, 1'b0);
    end
    for (int k = 0; k < 4; k++)
      chain_case($urandom_range(1, 6), $urandom_range(0, 3),
                 32'($urandom_range(0, 15)) << 2, 32'($urandom_range(0, 3)) << 2);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule